// File: doc/BRIEF.md
# Two-Wire Bus Slave with Memory and Register Targets

This block is the bus-facing front end of a chip that appears on a two-wire serial bus as two separate slaves. The bus master reaches a byte-addressed memory through one device-type code and a small register file for a clock and companion function through another. Both targets share one internal word pointer and one write-data path. The memory itself, the register file and the pad drivers are outside the block. The block presents an address, write data, one write strobe per target, and two read-data inputs.

SCL and SDA are sampled with the system clock through synchronizers. Start, Stop, data bits and the acknowledge slot are recovered from edges of the sampled lines. The slave never drives SDA high. It only asserts a pull-low enable, and it changes that enable only after it has seen SCL fall. The master can abort an operation at any time with a Start or a Stop. An asserted supply-fail input also aborts the operation and keeps the slave deaf to the bus until the next Start.

Top module: `twi_dual_slave`

## Requirements
- R1: The slave acknowledges an address byte only in two cases. Bits [7:4] must equal 4'b1010, which selects the memory target and its strobe `mem_we_o`, or 4'b1101, which selects the register target and its strobe `reg_we_o`. Bits [3:1] must also equal `strap_i`. Any other address byte gets no acknowledge, and every later byte is ignored until a new Start.
- R2: A Start, meaning SDA falls while SCL is high, aborts any transfer in progress and restarts address reception. A partly shifted data byte is never written, and the word pointer keeps its value.
- R3: A Stop, meaning SDA rises while SCL is high, ends the transfer. A partly shifted byte is discarded and SDA is released.
- R4: Bits are sampled on the rising edge of SCL, most significant bit first. Bit 0 of the address byte is the direction, with 1 meaning read.
- R5: In the ninth clock the slave pulls SDA low to acknowledge three kinds of byte: a matching address, the word-address byte, and each write data byte.
- R6: In a write, the first byte after the address loads the word pointer. Each later byte is written to the selected target at the pointer, and the pointer then increments, wrapping from 2^AW-1 to 0.
- R7: In a read, the slave sends the byte at the pointer and increments the pointer after each byte. It keeps sending while the master acknowledges. After a master no-acknowledge, it leaves SDA released and goes idle.
- R8: While `pwr_fail_i` is high, the slave aborts the transfer, gives no acknowledge and writes nothing. After `pwr_fail_i` falls, it ignores the bus until a new Start.
- R9: `sda_oe` changes only after a detected SCL falling edge, or when a Start, Stop or supply-fail event releases it. It never rises while SCL is still high.
- R10: After reset, `sda_oe`, `mem_we_o` and `reg_we_o` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as received from the pad |
| sda_i | input | 1 | Bus data line as received from the pad |
| strap_i | input | 3 | Board strap bits that must match address bits [3:1] |
| pwr_fail_i | input | 1 | Supply-fail indication; high aborts and mutes the slave |
| sda_oe | output | 1 | Pull-low enable for the open-drain SDA pad |
| addr_o | output | AW | Word pointer used for target reads and writes |
| wdata_o | output | 8 | Byte to write |
| mem_we_o | output | 1 | One-cycle write strobe to the memory target |
| reg_we_o | output | 1 | One-cycle write strobe to the register target |
| mem_rdata_i | input | 8 | Memory byte at `addr_o` |
| reg_rdata_i | input | 8 | Register byte at `addr_o` |

## Verification
The bench builds the block with its defaults: AW = 8, two synchronizer stages, codes 4'b1010 and 4'b1101, and the strap tied to 3'b011. An 8-bit pointer lets a two-byte write starting at 0xFF show the wrap to 0x00 in one transaction. A 16-entry register stub shows that register writes never reach the memory. Two synchronizer stages make the acknowledge delay after SCL falls short and fixed, so the bench can sample `sda_oe` both before and after it changes.

// File: rtl/twi_pkg.sv
package twi_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_PTR,
        ST_PTR_ACK,
        ST_WDATA,
        ST_WDATA_ACK,
        ST_RDATA,
        ST_RACK
    } twi_state_e;

    localparam int unsigned BYTE_BITS = 8;

endpackage

// File: rtl/twi_sync.sv
module twi_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q,
    output logic q_prev
);

    logic [STAGES:0] chain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= '1;
        end else begin
            chain_q <= {chain_q[STAGES-1:0], d};
        end
    end

    assign q      = chain_q[STAGES-1];
    assign q_prev = chain_q[STAGES];

endmodule

// File: rtl/twi_cond.sv
module twi_cond (
    input  logic scl,
    input  logic scl_prev,
    input  logic sda,
    input  logic sda_prev,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);

    always_comb begin
        scl_rise  = scl & ~scl_prev;
        scl_fall  = ~scl & scl_prev;
        start_det = scl & scl_prev & sda_prev & ~sda;
        stop_det  = scl & scl_prev & ~sda_prev & sda;
    end

endmodule

// File: rtl/twi_dual_slave.sv
module twi_dual_slave
    import twi_pkg::*;
#(
    parameter int unsigned AW          = 8,
    parameter int unsigned SYNC_STAGES = 2,
    parameter logic [3:0]  MEM_CODE    = 4'b1010,
    parameter logic [3:0]  REG_CODE    = 4'b1101
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          scl_i,
    input  logic          sda_i,
    input  logic [2:0]    strap_i,
    input  logic          pwr_fail_i,
    output logic          sda_oe,
    output logic [AW-1:0] addr_o,
    output logic [7:0]    wdata_o,
    output logic          mem_we_o,
    output logic          reg_we_o,
    input  logic [7:0]    mem_rdata_i,
    input  logic [7:0]    reg_rdata_i
);

    localparam int unsigned CW = $clog2(BYTE_BITS + 1);
    localparam logic [CW-1:0] LAST_BIT = CW'(BYTE_BITS);

    typedef struct packed {
        twi_state_e       st;
        logic [CW-1:0]    cnt;
        logic [7:0]       sh;
        logic [AW-1:0]    ptr;
        logic             tgt_reg;
        logic             rnw;
        logic             mack;
        logic             oe;
        logic             mem_we;
        logic             reg_we;
        logic [7:0]       wd;
    } slv_regs_t;

    localparam slv_regs_t RESET_VAL = '{
        st: ST_IDLE, cnt: '0, sh: '0, ptr: '0, tgt_reg: 1'b0, rnw: 1'b0,
        mack: 1'b0, oe: 1'b0, mem_we: 1'b0, reg_we: 1'b0, wd: '0
    };

    // line conditioning: index 0 = SCL, index 1 = SDA
    logic [1:0] raw_lines;
    logic [1:0] sync_lines;
    logic [1:0] prev_lines;

    assign raw_lines = {sda_i, scl_i};

    for (genvar g = 0; g < 2; g++) begin : g_line
        twi_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk    (clk),
            .rst_n  (rst_n),
            .d      (raw_lines[g]),
            .q      (sync_lines[g]),
            .q_prev (prev_lines[g])
        );
    end

    logic scl_rise, scl_fall, start_det, stop_det;
    logic sda_s;

    assign sda_s = sync_lines[1];

    twi_cond u_cond (
        .scl       (sync_lines[0]),
        .scl_prev  (prev_lines[0]),
        .sda       (sync_lines[1]),
        .sda_prev  (prev_lines[1]),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    slv_regs_t r_q, r_d;
    logic [7:0] rd_byte;
    logic       code_mem, code_reg, strap_ok;

    always_comb begin
        rd_byte  = r_q.tgt_reg ? reg_rdata_i : mem_rdata_i;
        code_mem = (r_q.sh[7:4] == MEM_CODE);
        code_reg = (r_q.sh[7:4] == REG_CODE);
        strap_ok = (r_q.sh[3:1] == strap_i);

        r_d        = r_q;
        r_d.mem_we = 1'b0;
        r_d.reg_we = 1'b0;

        if (pwr_fail_i) begin
            r_d.st  = ST_IDLE;
            r_d.oe  = 1'b0;
            r_d.cnt = '0;
        end else if (start_det) begin
            r_d.st  = ST_ADDR;
            r_d.oe  = 1'b0;
            r_d.cnt = '0;
        end else if (stop_det) begin
            r_d.st  = ST_IDLE;
            r_d.oe  = 1'b0;
            r_d.cnt = '0;
        end else begin
            unique case (r_q.st)
                ST_ADDR, ST_PTR, ST_WDATA: begin
                    if (scl_rise && r_q.cnt < LAST_BIT) begin
                        r_d.sh  = {r_q.sh[6:0], sda_s};
                        r_d.cnt = r_q.cnt + 1'b1;
                    end else if (scl_fall && r_q.cnt == LAST_BIT) begin
                        r_d.cnt = '0;
                        if (r_q.st == ST_ADDR) begin
                            if ((code_mem || code_reg) && strap_ok) begin
                                r_d.oe      = 1'b1;
                                r_d.st      = ST_ADDR_ACK;
                                r_d.tgt_reg = code_reg;
                                r_d.rnw     = r_q.sh[0];
                            end else begin
                                r_d.st = ST_IDLE;
                            end
                        end else if (r_q.st == ST_PTR) begin
                            r_d.ptr = r_q.sh[AW-1:0];
                            r_d.oe  = 1'b1;
                            r_d.st  = ST_PTR_ACK;
                        end else begin
                            r_d.wd     = r_q.sh;
                            r_d.mem_we = ~r_q.tgt_reg;
                            r_d.reg_we = r_q.tgt_reg;
                            r_d.oe     = 1'b1;
                            r_d.st     = ST_WDATA_ACK;
                        end
                    end
                end
                ST_ADDR_ACK: begin
                    if (scl_fall) begin
                        r_d.cnt = '0;
                        if (r_q.rnw) begin
                            r_d.sh = rd_byte;
                            r_d.oe = ~rd_byte[7];
                            r_d.st = ST_RDATA;
                        end else begin
                            r_d.oe = 1'b0;
                            r_d.st = ST_PTR;
                        end
                    end
                end
                ST_PTR_ACK, ST_WDATA_ACK: begin
                    if (scl_fall) begin
                        r_d.oe  = 1'b0;
                        r_d.cnt = '0;
                        r_d.st  = ST_WDATA;
                        if (r_q.st == ST_WDATA_ACK) begin
                            r_d.ptr = r_q.ptr + 1'b1;
                        end
                    end
                end
                ST_RDATA: begin
                    if (scl_rise && r_q.cnt < LAST_BIT) begin
                        r_d.cnt = r_q.cnt + 1'b1;
                    end else if (scl_fall && r_q.cnt == LAST_BIT) begin
                        r_d.oe  = 1'b0;
                        r_d.ptr = r_q.ptr + 1'b1;
                        r_d.st  = ST_RACK;
                    end else if (scl_fall && r_q.cnt != '0) begin
                        r_d.sh = {r_q.sh[6:0], 1'b0};
                        r_d.oe = ~r_q.sh[6];
                    end
                end
                ST_RACK: begin
                    if (scl_rise) begin
                        r_d.mack = ~sda_s;
                    end else if (scl_fall) begin
                        r_d.cnt = '0;
                        if (r_q.mack) begin
                            r_d.sh = rd_byte;
                            r_d.oe = ~rd_byte[7];
                            r_d.st = ST_RDATA;
                        end else begin
                            r_d.st = ST_IDLE;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= RESET_VAL;
        end else begin
            r_q <= r_d;
        end
    end

    assign sda_oe   = r_q.oe;
    assign addr_o   = r_q.ptr;
    assign wdata_o  = r_q.wd;
    assign mem_we_o = r_q.mem_we;
    assign reg_we_o = r_q.reg_we;

endmodule

// File: rtl/twi_dual_slave_chk.sv
module twi_dual_slave_chk (
    input logic clk,
    input logic rst_n,
    input logic scl_fall,
    input logic start_det,
    input logic stop_det,
    input logic pwr_fail_i,
    input logic sda_oe,
    input logic mem_we_o,
    input logic reg_we_o
);

    // R9: the pull-low enable moves only after an SCL fall or a releasing event
    a_r9_oe_on_event: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_oe != $past(sda_oe)) |-> $past(scl_fall || start_det || stop_det || pwr_fail_i));

    // R8: supply fail releases the line and blocks writes
    a_r8_pf_mute: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_fail_i |=> (!sda_oe && !mem_we_o && !reg_we_o));

    // R3: a Stop releases SDA
    a_r3_stop_release: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> !sda_oe);

    // R2: a Start releases SDA
    a_r2_start_release: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> !sda_oe);

    // R1: at most one target strobed
    a_r1_one_target: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({mem_we_o, reg_we_o}));

    // R6: a write strobe follows an SCL fall and lasts one cycle
    a_r6_we_after_fall: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we_o || reg_we_o) |-> $past(scl_fall));

    a_r6_we_single: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we_o || reg_we_o) |=> !(mem_we_o || reg_we_o));

endmodule

bind twi_dual_slave twi_dual_slave_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .scl_fall   (scl_fall),
    .start_det  (start_det),
    .stop_det   (stop_det),
    .pwr_fail_i (pwr_fail_i),
    .sda_oe     (sda_oe),
    .mem_we_o   (mem_we_o),
    .reg_we_o   (reg_we_o)
);

// File: tb/twi_dual_slave_test.sv
module twi_dual_slave_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic       pwr_fail = 1'b0;
    logic [2:0] strap = 3'b011;
    logic       sda_line;
    logic       sda_oe;
    logic [7:0] addr;
    logic [7:0] wdata;
    logic       mem_we, reg_we;
    logic [7:0] mem_rdata, reg_rdata;

    logic [7:0] mem [256];
    logic [7:0] regs [16];
    int mem_wr = 0;
    int reg_wr = 0;
    int n_chk = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    assign sda_line = sda_m & ~sda_oe;

    twi_dual_slave uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .scl_i       (scl_m),
        .sda_i       (sda_line),
        .strap_i     (strap),
        .pwr_fail_i  (pwr_fail),
        .sda_oe      (sda_oe),
        .addr_o      (addr),
        .wdata_o     (wdata),
        .mem_we_o    (mem_we),
        .reg_we_o    (reg_we),
        .mem_rdata_i (mem_rdata),
        .reg_rdata_i (reg_rdata)
    );

    // behavioural target stubs
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 256; i++) mem[i] <= 8'(i) ^ 8'h5A;
            for (int i = 0; i < 16; i++) regs[i] <= 8'hC0 + 8'(i);
        end else begin
            if (mem_we) begin
                mem[addr] <= wdata;
                mem_wr <= mem_wr + 1;
            end
            if (reg_we) begin
                regs[addr[3:0]] <= wdata;
                reg_wr <= reg_wr + 1;
            end
        end
    end

    assign mem_rdata = mem[addr];
    assign reg_rdata = regs[addr[3:0]];

    // {expected ack, address byte}; strap is 3'b011
    localparam logic [8:0] VEC [10] = '{
        {1'b1, 8'hA6}, {1'b1, 8'hD6}, {1'b0, 8'hA4}, {1'b0, 8'hA2},
        {1'b0, 8'hB6}, {1'b0, 8'h56}, {1'b0, 8'hD4}, {1'b0, 8'h96},
        {1'b0, 8'hE6}, {1'b0, 8'hDE}
    };

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: got %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic summary;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    task automatic bit_io(input logic b, output logic r);
        sda_m = b;
        wait_n(6);
        scl_m = 1'b1;
        wait_n(6);
        r = sda_line;
        wait_n(6);
        scl_m = 1'b0;
        wait_n(2);
    endtask

    task automatic start_c;
        sda_m = 1'b1;
        wait_n(6);
        scl_m = 1'b1;
        wait_n(6);
        sda_m = 1'b0;
        wait_n(6);
        scl_m = 1'b0;
        wait_n(2);
    endtask

    task automatic stop_c;
        sda_m = 1'b0;
        wait_n(6);
        scl_m = 1'b1;
        wait_n(6);
        sda_m = 1'b1;
        wait_n(8);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        logic r;
        for (int i = 7; i >= 0; i--) bit_io(b[i], r);
        bit_io(1'b1, r);
        ack = ~r;
    endtask

    task automatic recv_byte(input logic mack, output logic [7:0] d);
        logic r;
        for (int i = 7; i >= 0; i--) begin
            bit_io(1'b1, r);
            d[i] = r;
        end
        bit_io(~mack, r);
    endtask

    initial begin
        wait_n(150000);
        n_fail++;
        n_chk++;
        $display("FAIL R10 watchdog: got timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        logic ack;
        logic r;
        logic [7:0] d;
        int mw, rw;

        wait_n(5);
        chk("R10 oe in reset", sda_oe, 0);
        chk("R10 mem_we in reset", mem_we, 0);
        rst_n = 1'b1;
        wait_n(5);
        chk("R10 oe after reset", sda_oe, 0);
        chk("R10 reg_we after reset", reg_we, 0);

        // R1: address decode table
        for (int i = 0; i < 10; i++) begin
            start_c();
            send_byte(VEC[i][7:0], ack);
            chk($sformatf("R1 addr %0h", VEC[i][7:0]), ack, VEC[i][8]);
            if (!VEC[i][8]) begin
                send_byte(8'hA6, ack);
                chk("R1 idle until start", ack, 0);
            end
            stop_c();
        end

        // R9, R5: ack appears only after SCL falls
        start_c();
        for (int i = 7; i >= 1; i--) bit_io(VEC[0][i], r);
        sda_m = 1'b0;
        wait_n(6);
        scl_m = 1'b1;
        wait_n(12);
        chk("R9 no ack while SCL high", sda_oe, 0);
        scl_m = 1'b0;
        wait_n(1);
        chk("R9 no ack right after fall", sda_oe, 0);
        wait_n(5);
        chk("R5 ack driven after fall", sda_oe, 1);
        bit_io(1'b1, r);
        chk("R5 ack seen on line", r, 0);
        stop_c();

        // R6, R5: sequential write
        mw = mem_wr;
        start_c();
        send_byte(8'hA6, ack);
        send_byte(8'h20, ack);
        chk("R5 ack pointer byte", ack, 1);
        send_byte(8'h11, ack);
        chk("R5 ack data byte", ack, 1);
        send_byte(8'h22, ack);
        send_byte(8'h33, ack);
        stop_c();
        chk("R6 write count", mem_wr - mw, 3);
        chk("R6 mem[20]", mem[8'h20], 8'h11);
        chk("R6 mem[21]", mem[8'h21], 8'h22);
        chk("R6 mem[22]", mem[8'h22], 8'h33);

        // R7, R4, R2: sequential read via repeated start
        start_c();
        send_byte(8'hA6, ack);
        send_byte(8'h20, ack);
        start_c();
        send_byte(8'hA7, ack);
        chk("R7 read addr ack", ack, 1);
        recv_byte(1'b1, d);
        chk("R7 read byte 0", d, 8'h11);
        recv_byte(1'b1, d);
        chk("R4 read byte 1", d, 8'h22);
        recv_byte(1'b0, d);
        chk("R7 read byte 2", d, 8'h33);
        wait_n(4);
        chk("R7 released after nack", sda_oe, 0);
        send_byte(8'hA6, ack);
        chk("R7 idle after nack", ack, 0);
        stop_c();

        // R6: pointer wrap
        start_c();
        send_byte(8'hA6, ack);
        send_byte(8'hFF, ack);
        send_byte(8'hE1, ack);
        send_byte(8'hE2, ack);
        stop_c();
        chk("R6 mem[FF]", mem[8'hFF], 8'hE1);
        chk("R6 wrap mem[00]", mem[8'h00], 8'hE2);

        // R1: register target
        mw = mem_wr;
        rw = reg_wr;
        start_c();
        send_byte(8'hD6, ack);
        send_byte(8'h05, ack);
        send_byte(8'h9C, ack);
        stop_c();
        chk("R1 reg write count", reg_wr - rw, 1);
        chk("R1 no mem write", mem_wr - mw, 0);
        chk("R1 regs[5]", regs[5], 8'h9C);
        start_c();
        send_byte(8'hD6, ack);
        send_byte(8'h05, ack);
        start_c();
        send_byte(8'hD7, ack);
        recv_byte(1'b0, d);
        stop_c();
        chk("R1 reg read", d, 8'h9C);

        // R3: stop aborts a partial byte
        mw = mem_wr;
        start_c();
        send_byte(8'hA6, ack);
        send_byte(8'h50, ack);
        for (int i = 0; i < 4; i++) bit_io(1'b1, r);
        stop_c();
        chk("R3 no write on stop", mem_wr - mw, 0);
        chk("R3 oe released", sda_oe, 0);
        start_c();
        send_byte(8'hA7, ack);
        recv_byte(1'b0, d);
        stop_c();
        chk("R3 mem[50] intact", d, 8'h50 ^ 8'h5A);

        // R2: start aborts a partial byte
        mw = mem_wr;
        start_c();
        send_byte(8'hA6, ack);
        send_byte(8'h60, ack);
        for (int i = 0; i < 3; i++) bit_io(1'b0, r);
        start_c();
        send_byte(8'hA7, ack);
        chk("R2 restart ack", ack, 1);
        recv_byte(1'b0, d);
        stop_c();
        chk("R2 mem[60] intact", d, 8'h60 ^ 8'h5A);
        chk("R2 no write on start", mem_wr - mw, 0);

        // R8: supply fail mid-byte
        mw = mem_wr;
        start_c();
        send_byte(8'hA6, ack);
        send_byte(8'h40, ack);
        for (int i = 0; i < 4; i++) bit_io(1'b1, r);
        pwr_fail = 1'b1;
        wait_n(4);
        for (int i = 0; i < 4; i++) bit_io(1'b1, r);
        bit_io(1'b1, r);
        chk("R8 no ack during fail", r, 1);
        pwr_fail = 1'b0;
        send_byte(8'hA6, ack);
        chk("R8 deaf until start", ack, 0);
        stop_c();
        chk("R8 no write", mem_wr - mw, 0);
        chk("R8 mem[40] intact", mem[8'h40], 8'h40 ^ 8'h5A);
        pwr_fail = 1'b1;
        start_c();
        send_byte(8'hA6, ack);
        chk("R8 start ignored while failing", ack, 0);
        stop_c();
        pwr_fail = 1'b0;
        start_c();
        send_byte(8'hA6, ack);
        chk("R8 recovers after start", ack, 1);
        stop_c();

        summary();
        $finish;
    end

endmodule